// File: doc/BRIEF.md
# IF Digital Downconverter with Decimate-by-Four

This block translates an undersampled intermediate-frequency signal to complex baseband and lowers its sample rate. Real signed samples enter with a valid strobe. A 28-bit phase accumulator drives a sine/cosine table. A complex mixer multiplies each sample by the two oscillator phases. An 8-tap symmetric low-pass filter then emits one I/Q pair for every four input samples, rounded and clamped to 16 bits.

The oscillator frequency is FREQ × fs / 2^28. An IF that aliases to fs/8, for example 70 MHz sampled at 80 MHz, which lands at 10 MHz, is therefore brought to DC with FREQ = 0x2000000. A small register write port loads the tuning word and chooses between real output, where only I carries data, and complex I/Q output.

Top module: `ddc_decim4`

## Requirements
- R1: A synchronous active-high `rst` clears the phase accumulator, the filter taps and the decimation phase, drives `out_valid`, `out_i` and `out_q` to zero, and resets FREQ to 0 and the mode to real.
- R2: A cycle with `wr_en` high and `wr_addr` = 0 loads FREQ from `wr_data[27:0]`. With `wr_addr` = 1 it loads the mode from `wr_data[0]`, where 1 selects complex and 0 selects real.
- R3: Each sample taken with `in_valid` high is mixed at the phase that the accumulator holds before that sample, and the accumulator then adds FREQ. The first sample after reset is therefore mixed at phase zero.
- R4: The top 10 accumulator bits address a quarter-wave sine table of amplitude 16383, with each entry rounded to the nearest integer. Cosine is sine advanced by a quarter turn, so phase zero gives cos = 16383 and sin = 0.
- R5: The mixer forms I = x·cos and Q = −x·sin. Each 27-bit product is shifted right arithmetically by 9, which rounds toward minus infinity, to an 18-bit internal sample.
- R6: `out_valid` pulses for exactly one clock per four input samples, counted from reset.
- R7: The filter weights are 1,3,5,7,7,5,3,1, and the sum is divided by 32, giving unity gain at DC and exact nulls at fs/4 and fs/2. A tone at fs/8 with FREQ = 0x2000000 therefore settles to constant I/Q values.
- R8: The filter sum is divided by 32 with ties rounded upward, then clamped to the range [−32768, 32767].
- R9: In real mode `out_q` is zero at every output sample, while `out_i` is computed exactly as in complex mode.
- R10: A FREQ write applies from the next input sample and leaves the accumulator phase untouched. The accumulator holds its value on cycles with no input sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input sample strobe |
| in_data | input | 12 | Signed IF sample |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0 = tuning word, 1 = mode |
| wr_data | input | 28 | Write data |
| out_valid | output | 1 | One-clock strobe per output pair |
| out_i | output | 16 | Signed in-phase output |
| out_q | output | 16 | Signed quadrature output, zero in real mode |

## Verification
Constant inputs at zero tuning yield exact values, from which the bench can predict the rounding and the partial first output after reset, the floor behaviour of the product shift, and clamping at both full-scale extremes. Cosine and sine tones at fs/8 with the 0x2000000 tuning word separate a correct phase origin and the sign of Q from a one-sample offset or a flipped quadrature. A retune to zero after three samples freezes the oscillator at 135 degrees, which shows whether a write reset the accumulator. A tone in real mode confirms that Q stays silent while I is unchanged.

// File: rtl/ddc_decim4.sv
module ddc_decim4 #(
  parameter int IN_W   = 12,
  parameter int OUT_W  = 16,
  parameter int PH_W   = 28,
  parameter int LUT_AW = 10,
  parameter int AMP_W  = 15,
  parameter int MIX_W  = 18,
  parameter int NT     = 8,
  parameter int DEC    = 4,
  parameter int OUT_SH = 5
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  input  logic signed [IN_W-1:0]  in_data,
  input  logic                    wr_en,
  input  logic                    wr_addr,
  input  logic [PH_W-1:0]         wr_data,
  output logic                    out_valid,
  output logic signed [OUT_W-1:0] out_i,
  output logic signed [OUT_W-1:0] out_q
);

  localparam int AMP    = (1 << (AMP_W - 1)) - 1;
  localparam int QN     = 1 << (LUT_AW - 2);
  localparam int QW     = LUT_AW - 1;
  localparam int PROD_W = IN_W + AMP_W;
  localparam int MIX_SH = PROD_W - MIX_W;
  localparam int SUM_W  = MIX_W + $clog2(NT * NT);
  localparam int CW     = $clog2(DEC);
  localparam logic signed [SUM_W-1:0] RND = SUM_W'(1 << (OUT_SH - 1));
  localparam logic signed [SUM_W-1:0] HI  = SUM_W'((1 << (OUT_W - 1)) - 1);
  localparam logic signed [SUM_W-1:0] LO  = -HI - 1;

  logic [PH_W-1:0] acc, freq;
  logic            cplx;

  // quarter-wave sine table, one extra entry for the 90 degree point
  logic signed [AMP_W-1:0] qtab [QN+1];
  for (genvar g = 0; g <= QN; g++) begin : g_qtab
    localparam real ANG = 1.5707963267948966 * real'(g) / real'(QN);
    assign qtab[g] = AMP_W'($rtoi($sin(ANG) * real'(AMP) + 0.5));
  end

  // lane 0 = sine, lane 1 = cosine
  logic [LUT_AW-1:0]       lph  [2];
  logic signed [AMP_W-1:0] lval [2];
  assign lph[0] = acc[PH_W-1 -: LUT_AW];
  assign lph[1] = acc[PH_W-1 -: LUT_AW] + LUT_AW'(QN);

  for (genvar l = 0; l < 2; l++) begin : g_lane
    logic [QW-1:0] fwd, adr;
    assign fwd     = {1'b0, lph[l][LUT_AW-3:0]};
    assign adr     = lph[l][LUT_AW-2] ? QW'(QN) - fwd : fwd;
    assign lval[l] = lph[l][LUT_AW-1] ? -qtab[adr] : qtab[adr];
  end

  logic signed [AMP_W-1:0]  sin_v, cos_v;
  logic signed [PROD_W-1:0] prod_i, prod_q;
  assign sin_v  = lval[0];
  assign cos_v  = lval[1];
  assign prod_i = in_data * cos_v;
  assign prod_q = -(in_data * sin_v);

  logic                    mix_v;
  logic signed [MIX_W-1:0] mix_i, mix_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc   <= '0;
      freq  <= '0;
      cplx  <= 1'b0;
      mix_v <= 1'b0;
      mix_i <= '0;
      mix_q <= '0;
    end else begin
      if (wr_en) begin
        if (!wr_addr) freq <= wr_data;
        else          cplx <= wr_data[0];
      end
      mix_v <= in_valid;
      if (in_valid) begin
        acc   <= acc + freq;
        mix_i <= MIX_W'(prod_i >>> MIX_SH);
        mix_q <= MIX_W'(prod_q >>> MIX_SH);
      end
    end
  end

  // filter delay line, nxt_* is the line after the incoming sample shifts in
  logic signed [MIX_W-1:0] tap_i [NT];
  logic signed [MIX_W-1:0] tap_q [NT];
  logic signed [MIX_W-1:0] nxt_i [NT];
  logic signed [MIX_W-1:0] nxt_q [NT];
  assign nxt_i[0] = mix_i;
  assign nxt_q[0] = mix_q;
  for (genvar k = 1; k < NT; k++) begin : g_link
    assign nxt_i[k] = tap_i[k-1];
    assign nxt_q[k] = tap_q[k-1];
  end

  function automatic int coef(input int k);
    return (k < NT / 2) ? 2 * k + 1 : 2 * (NT - 1 - k) + 1;
  endfunction

  logic signed [SUM_W-1:0] sum_i, sum_q;
  always_comb begin
    sum_i = '0;
    sum_q = '0;
    for (int k = 0; k < NT; k++) begin
      sum_i = sum_i + SUM_W'(nxt_i[k]) * SUM_W'(coef(k));
      sum_q = sum_q + SUM_W'(nxt_q[k]) * SUM_W'(coef(k));
    end
  end

  function automatic logic signed [OUT_W-1:0] rnd_sat(input logic signed [SUM_W-1:0] s);
    logic signed [SUM_W-1:0] r;
    r = (s + RND) >>> OUT_SH;
    if (r > HI) return HI[OUT_W-1:0];
    if (r < LO) return LO[OUT_W-1:0];
    return r[OUT_W-1:0];
  endfunction

  logic [CW-1:0] dph;

  always_ff @(posedge clk) begin
    if (rst) begin
      tap_i     <= '{default: '0};
      tap_q     <= '{default: '0};
      dph       <= '0;
      out_valid <= 1'b0;
      out_i     <= '0;
      out_q     <= '0;
    end else begin
      out_valid <= 1'b0;
      if (mix_v) begin
        tap_i <= nxt_i;
        tap_q <= nxt_q;
        dph   <= dph + 1'b1;
        if (dph == CW'(DEC - 1)) begin
          out_valid <= 1'b1;
          out_i     <= rnd_sat(sum_i);
          out_q     <= cplx ? rnd_sat(sum_q) : '0;
        end
      end
    end
  end

  AST_RST_CLEAR: assert property (@(posedge clk) $past(rst) |-> (acc == '0 && !out_valid && out_i == '0 && out_q == '0)) else $error("reset state"); // R1
  AST_LUT_RANGE: assert property (@(posedge clk) disable iff (rst) (sin_v <= AMP && sin_v >= -AMP && cos_v <= AMP && cos_v >= -AMP)) else $error("lut range"); // R4
  AST_ONE_PULSE: assert property (@(posedge clk) disable iff (rst) out_valid |=> !out_valid) else $error("pulse width"); // R6
  AST_OUT_AFTER_MIX: assert property (@(posedge clk) disable iff (rst) $rose(out_valid) |-> $past(mix_v)) else $error("strobe source"); // R6
  AST_REAL_Q_ZERO: assert property (@(posedge clk) disable iff (rst) (out_valid && !$past(cplx)) |-> out_q == '0) else $error("real mode q"); // R9
  AST_ACC_IDLE: assert property (@(posedge clk) disable iff (rst) !in_valid |=> $stable(acc)) else $error("acc moved"); // R10

endmodule

// File: tb/ddc_decim4_bench.sv
`timescale 1ns/1ps
module ddc_decim4_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic signed [11:0] in_data = '0;
  logic wr_en = 1'b0;
  logic wr_addr = 1'b0;
  logic [27:0] wr_data = '0;
  logic out_valid;
  logic signed [15:0] out_i, out_q;

  ddc_decim4 u_ddc_decim4 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .out_valid(out_valid), .out_i(out_i), .out_q(out_q)
  );

  always #2 clk = ~clk;

  int total = 0;
  int bad = 0;
  int n_out = 0;
  int q_nz = 0;
  int last_i = 0;
  int last_q = 0;
  int hist [256];

  always @(negedge clk) begin
    if (out_valid) begin
      hist[n_out % 256] = out_i;
      last_i = out_i;
      last_q = out_q;
      if (out_q != 0) q_nz = q_nz + 1;
      n_out = n_out + 1;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total + 1, bad + 1);
    $finish;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic near(input string req, input int act, input int exp, input int tol);
    chk((act - exp <= tol) && (exp - act <= tol), req, act, exp);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b0; wr_en = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wr(input bit a, input int d);
    @(negedge clk);
    in_valid = 1'b0;
    wr_en = 1'b1; wr_addr = a; wr_data = 28'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic sample(input int x);
    @(negedge clk);
    in_valid = 1'b1;
    in_data = 12'(x);
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    in_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  function automatic int tone(input int n, input bit use_sin);
    real ang, r;
    ang = 3.14159265358979 * real'(n) / 4.0;
    r = 1000.0 * (use_sin ? $sin(ang) : $cos(ang));
    return $rtoi(r + ((r >= 0.0) ? 0.5 : -0.5));
  endfunction

  task automatic t_saturation();
    do_reset();
    wr(1'b1, 1);
    for (int n = 0; n < 16; n++) sample(2047);
    idle(6);
    chk(last_i == 32767, "R8 positive clamp", last_i, 32767);
    chk(last_q == 0, "R4 sin at phase zero", last_q, 0);
    for (int n = 0; n < 16; n++) sample(-2048);
    idle(6);
    chk(last_i == -32768, "R8 negative clamp", last_i, -32768);
  endtask

  task automatic t_reset_state();
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    chk(out_valid == 1'b0, "R1 reset out_valid", int'(out_valid), 0);
    chk(out_i == 0 && out_q == 0, "R1 reset outputs", int'(out_i), 0);
    rst = 1'b0;
  endtask

  task automatic t_dc_exact();
    int base;
    do_reset();
    wr(1'b1, 1);
    base = n_out;
    for (int n = 0; n < 8; n++) sample(100);
    idle(6);
    chk(n_out - base == 2, "R6 outputs per 8 inputs", n_out - base, 2);
    // first output sees 4 cleared taps: 3199*16/32 = 1599.5 rounds up
    chk(hist[base % 256] == 1600, "R1 R8 first output after reset", hist[base % 256], 1600);
    chk(hist[(base + 1) % 256] == (100 * 16383) >>> 9, "R3 R4 R5 settled DC", hist[(base + 1) % 256], (100 * 16383) >>> 9);
    chk(last_q == 0, "R5 Q at zero phase", last_q, 0);
    for (int n = 0; n < 12; n++) sample(-100);
    idle(6);
    chk(last_i == ((-100 * 16383) >>> 9), "R5 floor shift negative", last_i, (-100 * 16383) >>> 9);
  endtask

  task automatic t_tone(input bit use_sin, input bit cplx);
    int base, qb, e;
    do_reset();
    wr(1'b0, 32'h2000000);
    wr(1'b1, cplx ? 1 : 0);
    base = n_out;
    qb = q_nz;
    for (int n = 0; n < 64; n++) sample(tone(n, use_sin));
    idle(6);
    e = $rtoi(1000.0 * 16383.0 / 1024.0 + 0.5);
    chk(n_out - base == 16, "R6 count for 64 inputs", n_out - base, 16);
    if (!cplx) begin
      chk(q_nz == qb, "R2 R9 real mode Q silent", q_nz - qb, 0);
      near("R9 real mode I", last_i, use_sin ? 0 : e, 40);
    end else if (!use_sin) begin
      near("R3 R7 cosine tone I", last_i, e, 40);
      near("R7 cosine tone Q", last_q, 0, 40);
    end else begin
      near("R5 R7 sine tone Q sign", last_q, -e, 40);
      near("R7 sine tone I", last_i, 0, 40);
    end
  endtask

  task automatic t_retune();
    int c, ei, eq;
    do_reset();
    wr(1'b0, 32'h2000000);
    wr(1'b1, 1);
    for (int n = 0; n < 3; n++) sample(0);
    wr(1'b0, 0);
    for (int n = 0; n < 16; n++) sample(100);
    idle(6);
    c = $rtoi(16383.0 * $sqrt(0.5) + 0.5);
    ei = (-100 * c) >>> 9;
    eq = (-100 * c) >>> 9;
    chk(last_i == ei, "R10 phase kept after retune I", last_i, ei);
    chk(last_q == eq, "R10 phase kept after retune Q", last_q, eq);
  endtask

  initial begin
    do_reset();
    t_saturation();
    t_reset_state();
    t_dc_exact();
    t_tone(1'b0, 1'b1);
    t_tone(1'b1, 1'b1);
    t_tone(1'b0, 1'b0);
    t_retune();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule